// File: doc/BRIEF.md
# UART Transmitter with Line Control

This block is the transmit half of a memory-mapped serial port. Software pushes bytes into a 16-entry queue through a data register. A serializer takes each byte out of the queue and sends it as one asynchronous frame on a single output line. The frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line stays high when nothing is being sent.

The bit rate comes from a divisor register. A line-control register picks the character size, the parity and the number of stop bits, turns the transmitter on or off, and can hold the line in a break. A status register reports two things: a frame is in flight, so the divisor must not be changed yet, and a byte was lost because the queue was full. A queue-control register clears the queue with request bits that clear themselves, and a level register reports how many entries are occupied.

Registers are accessed as words. A write takes effect on the clock edge where `reg_wr` is high, and reads are combinational from `reg_addr`. The word offsets are: 0 data (write only), 1 line control, 2 divisor, 3 status, 4 queue control, 5 queue level.

Top module: `uart_tx_lc`

## Requirements
- R1: After reset the line is high. Line control, status, queue control and queue level all read 0, and the divisor reads 7.
- R2: Each write to offset 0 stores one byte in the queue. Bits [4:0] of offset 5 give the number of stored entries, from 0 to 16, and bytes are sent in the order they were written.
- R3: A data write while the queue holds 16 entries is dropped and leaves the stored bytes unchanged. It also sets status bit 1, which stays set until software writes 1 to status bit 1.
- R4: A frame is a low start bit, then data bits LSB first, then stop bits at 1, with the line idle at 1. Line-control bit 2 = 1 selects 8 data bits; bit 2 = 0 selects 7 data bits, which are the byte's bits [6:0].
- R5: Line-control bit 4 = 1 adds a parity bit after the data. With bit 5 = 0 the parity is even: the bit equals the XOR of the data bits sent. With bit 5 = 1 the parity is odd: the bit is the inverse of that XOR.
- R6: Line-control bit 3 = 1 sends two stop bits, and bit 3 = 0 sends one.
- R7: Every bit lasts (D+1)·OVS·REF_DIV clock cycles, where D is divisor bits [9:0]. Divisor bits [15:10] are stored and read back unchanged.
- R8: Status bit 5 is 1 from the cycle a frame starts until its last stop bit ends. A divisor write while status bit 5 is 1 is ignored.
- R9: While line-control bit 9 is 1, the line is held low.
- R10: No frame starts while line-control bit 0 is 0. Queued bytes stay in place and are sent once bit 0 is set.
- R11: Writing 1 to queue-control bit 2 or bit 3 sets that bit. It reads back as 1 for exactly one cycle, after which both the bit and the queue level are 0. Queue-control bit 0 is stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` |
| txd | output | 1 | Serial transmit line |

## Verification
A wrong serializer state shows up on `txd` within one bit period. Examples are a misplaced bit, a wrong parity value, or a missing second stop bit, which lets the next start bit arrive early. The bench finds these by sampling each bit at its midpoint against a frame it has built itself. Faults in the queue pointers or the level count appear in the level register in the cycle after the write. They also appear as a reordered or missing byte when the queue drains. A wrong divisor or bit counter changes the measured length of the start bit from the first bit sent.

// File: rtl/uart_tx_lc_pkg.sv
package uart_tx_lc_pkg;
    // register word offsets
    localparam int A_DATA = 0;
    localparam int A_LCR  = 1;
    localparam int A_DIV  = 2;
    localparam int A_STAT = 3;
    localparam int A_FCTL = 4;
    localparam int A_FIDX = 5;

    // line-control bit positions
    localparam int LC_TXEN  = 0;
    localparam int LC_RXEN  = 1;
    localparam int LC_CH8   = 2;
    localparam int LC_STOP2 = 3;
    localparam int LC_PEN   = 4;
    localparam int LC_PODD  = 5;
    localparam int LC_BRK   = 9;

    // status bit positions
    localparam int ST_OVF     = 1;
    localparam int ST_DIVBUSY = 5;

    // queue-control bit positions
    localparam int FC_EN   = 0;
    localparam int FC_RSTA = 2;
    localparam int FC_RSTB = 3;

    typedef enum logic [2:0] {
        SH_IDLE  = 3'd0,
        SH_START = 3'd1,
        SH_DATA  = 3'd2,
        SH_PAR   = 3'd3,
        SH_STOP  = 3'd4
    } sh_state_e;

    typedef struct packed {
        logic ch8;
        logic stop2;
        logic pen;
        logic podd;
    } frame_cfg_t;
endpackage

// File: rtl/uart_tx_lc_fifo.sv
module uart_tx_lc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[q.rp];
    assign level   = q.cnt;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (push_ok) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
            if (pop_ok)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= wdata;
    end
endmodule

// File: rtl/uart_tx_lc_baud.sv
module uart_tx_lc_baud #(
    parameter int DIV_W    = 10,
    parameter int BIT_MULT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int MW = (BIT_MULT > 1) ? $clog2(BIT_MULT) : 1;
    localparam int CW = DIV_W + MW + 1;

    logic [CW-1:0] cnt_q, cnt_d, limit;

    assign limit = (CW'(div) + CW'(1)) * CW'(BIT_MULT) - CW'(1);
    assign tick  = run && (cnt_q == limit);

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_tx_lc_shift.sv
module uart_tx_lc_shift
    import uart_tx_lc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ldata,
    input  frame_cfg_t    cfg,
    input  logic          tick,
    output logic          line,
    output logic          busy
);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        sh_state_e     st;
        logic [DW-1:0] sh;
        logic [BW-1:0] bitn;
        logic          par;
        logic          stop_second;
        frame_cfg_t    cfg;
    } shift_st_t;

    shift_st_t q, d;
    logic [BW-1:0] last_bit;

    assign last_bit = q.cfg.ch8 ? BW'(DW - 1) : BW'(DW - 2);
    assign busy     = (q.st != SH_IDLE);

    always_comb begin
        d = q;
        case (q.st)
            SH_IDLE: begin
                if (load) begin
                    d.st          = SH_START;
                    d.sh          = ldata;
                    d.cfg         = cfg;
                    d.bitn        = '0;
                    d.stop_second = 1'b0;
                    d.par         = cfg.podd ^ (cfg.ch8 ? ^ldata : ^ldata[DW-2:0]);
                end
            end
            SH_START: if (tick) d.st = SH_DATA;
            SH_DATA: begin
                if (tick) begin
                    d.sh = q.sh >> 1;
                    if (q.bitn == last_bit) d.st = q.cfg.pen ? SH_PAR : SH_STOP;
                    else                    d.bitn = q.bitn + 1'b1;
                end
            end
            SH_PAR: if (tick) d.st = SH_STOP;
            SH_STOP: begin
                if (tick) begin
                    if (q.cfg.stop2 && !q.stop_second) d.stop_second = 1'b1;
                    else                               d.st = SH_IDLE;
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_comb begin
        case (q.st)
            SH_START: line = 1'b0;
            SH_DATA:  line = q.sh[0];
            SH_PAR:   line = q.par;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SH_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/uart_tx_lc.sv
module uart_tx_lc
    import uart_tx_lc_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int REG_W   = 16,
    parameter int DEPTH   = 16,
    parameter int DIV_W   = 10,
    parameter int OVS     = 16,
    parameter int REF_DIV = 1,
    parameter int DIV_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              txd
);
    localparam int BIT_MULT = OVS * REF_DIV;
    localparam int LVL_W    = $clog2(DEPTH + 1);
    localparam int CHAR_W   = 8;
    localparam logic [REG_W-1:0] LCR_MASK =
        REG_W'((1 << LC_TXEN) | (1 << LC_RXEN) | (1 << LC_CH8) | (1 << LC_STOP2) |
               (1 << LC_PEN) | (1 << LC_PODD) | (1 << LC_BRK));

    typedef struct packed {
        logic [REG_W-1:0] lcr;
        logic [REG_W-1:0] div;
        logic             fen;
        logic             rst_a;
        logic             rst_b;
        logic             ovf;
    } regs_t;

    regs_t q, d;

    logic              wr_data, wr_lcr, wr_div, wr_stat, wr_fctl;
    logic              busy, pop, clr, full, empty, tick, line;
    logic [CHAR_W-1:0] head;
    logic [LVL_W-1:0]  level;
    frame_cfg_t        cfg;

    assign wr_data = reg_wr && (reg_addr == ADDR_W'(A_DATA));
    assign wr_lcr  = reg_wr && (reg_addr == ADDR_W'(A_LCR));
    assign wr_div  = reg_wr && (reg_addr == ADDR_W'(A_DIV));
    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));
    assign wr_fctl = reg_wr && (reg_addr == ADDR_W'(A_FCTL));

    assign clr = q.rst_a || q.rst_b;
    assign pop = !busy && q.lcr[LC_TXEN] && !empty && !clr;

    assign cfg.ch8   = q.lcr[LC_CH8];
    assign cfg.stop2 = q.lcr[LC_STOP2];
    assign cfg.pen   = q.lcr[LC_PEN];
    assign cfg.podd  = q.lcr[LC_PODD];

    always_comb begin
        d = q;
        // a pending queue reset lasts one cycle
        d.rst_a = 1'b0;
        d.rst_b = 1'b0;
        if (wr_data && full)           d.ovf = 1'b1;
        if (wr_stat && reg_wdata[ST_OVF]) d.ovf = 1'b0;
        if (wr_lcr)                    d.lcr = reg_wdata & LCR_MASK;
        if (wr_div && !busy)           d.div = reg_wdata;
        if (wr_fctl) begin
            d.fen   = reg_wdata[FC_EN];
            d.rst_a = reg_wdata[FC_RSTA];
            d.rst_b = reg_wdata[FC_RSTB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{div: REG_W'(DIV_RST), default: '0};
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_LCR):  reg_rdata = q.lcr;
            ADDR_W'(A_DIV):  reg_rdata = q.div;
            ADDR_W'(A_STAT): begin
                reg_rdata[ST_OVF]     = q.ovf;
                reg_rdata[ST_DIVBUSY] = busy;
            end
            ADDR_W'(A_FCTL): begin
                reg_rdata[FC_EN]   = q.fen;
                reg_rdata[FC_RSTA] = q.rst_a;
                reg_rdata[FC_RSTB] = q.rst_b;
            end
            ADDR_W'(A_FIDX): reg_rdata = REG_W'(level);
            default:         reg_rdata = '0;
        endcase
    end

    uart_tx_lc_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (wr_data),
        .wdata (reg_wdata[CHAR_W-1:0]),
        .pop   (pop),
        .rdata (head),
        .level (level),
        .full  (full),
        .empty (empty)
    );

    uart_tx_lc_baud #(.DIV_W(DIV_W), .BIT_MULT(BIT_MULT)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (q.div[DIV_W-1:0]),
        .tick  (tick)
    );

    uart_tx_lc_shift #(.DW(CHAR_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pop),
        .ldata (head),
        .cfg   (cfg),
        .tick  (tick),
        .line  (line),
        .busy  (busy)
    );

    assign txd = q.lcr[LC_BRK] ? 1'b0 : line;
endmodule

// File: rtl/uart_tx_lc_chk.sv
module uart_tx_lc_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             busy,
    input logic             brk,
    input logic             txen,
    input logic [LVL_W-1:0] level,
    input logic             wr_data,
    input logic             wr_div,
    input logic             wr_fctl,
    input logic             pop,
    input logic             clr,
    input logic             ovf,
    input logic [REG_W-1:0] div
);
    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && level == LVL_W'(DEPTH) && !pop && !clr) |=> (level == LVL_W'(DEPTH) && ovf)); // R3

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |-> txd); // R4

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_div) |=> $stable(div)); // R8

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd); // R9

    AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !txen) |=> !busy); // R10

    AST_RESET_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_fctl) |=> (!clr && level == '0)); // R11
endmodule

bind uart_tx_lc uart_tx_lc_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .busy    (busy),
    .brk     (q.lcr[9]),
    .txen    (q.lcr[0]),
    .level   (level),
    .wr_data (wr_data),
    .wr_div  (wr_div),
    .wr_fctl (wr_fctl),
    .pop     (pop),
    .clr     (clr),
    .ovf     (q.ovf),
    .div     (q.div)
);

// File: tb/uart_tx_lc_bench.sv
module uart_tx_lc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int RW = 16;
    localparam int MULT = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          txd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_tx_lc u_uart_tx_lc (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .txd       (txd)
    );

    function automatic int bit_period(input int dv);
        return (dv + 1) * MULT;
    endfunction

    function automatic int exp_parity(input int data, input bit ch8, input bit odd);
        logic [7:0] v;
        v = ch8 ? 8'(data) : 8'(data & 8'h7F);
        return int'((^v) ^ odd);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = AW'(a);
        reg_wdata = RW'(v);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = AW'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_idle();
        int v;
        int n = 0;
        do begin
            @(negedge clk);
            rd(3, v);
            n++;
        end while (v[5] && n < 50000);
    endtask

    task automatic rx_frame(input bit c8, input bit pe, input bit ts, input int per,
                            output int data, output int par, output int ok);
        int n = 0;
        data = 0;
        par = 0;
        ok = 1;
        while (txd !== 1'b0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (txd !== 1'b0) begin
            ok = 0;
            data = -1;
            return;
        end
        repeat (per / 2) @(negedge clk);
        if (txd !== 1'b0) ok = 0;
        for (int i = 0; i < (c8 ? 8 : 7); i++) begin
            repeat (per) @(negedge clk);
            data = data | (int'(txd) << i);
        end
        if (pe) begin
            repeat (per) @(negedge clk);
            par = int'(txd);
        end
        repeat (per) @(negedge clk);
        if (txd !== 1'b1) ok = 0;
        if (ts) begin
            repeat (per) @(negedge clk);
            if (txd !== 1'b1) ok = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, d, p, ok, cnt;
        int q[16];
        int unsigned seed;
        seed = $urandom(32'h5EED1);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 txd", int'(txd), 1);
        rd(1, v); check("R1 line control", v, 0);
        rd(2, v); check("R1 divisor", v, 7);
        rd(3, v); check("R1 status", v, 0);
        rd(4, v); check("R1 queue control", v, 0);
        rd(5, v); check("R1 level", v, 0);

        // R7 upper divisor bits kept, bit period from low field
        wr(2, 16'hFC01);
        rd(2, v); check("R7 divisor readback", v, 16'hFC01);
        wr(0, 8'h55);
        wr(1, 16'h0005);
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0) begin
            cnt++;
            @(negedge clk);
        end
        check("R7 start bit length", cnt, bit_period(1));
        wait_idle();
        check("R4 idle high after frame", int'(txd), 1);

        // R2 occupancy, R3 full drop and order
        wr(1, 16'h0004);
        wr(2, 0);
        rd(5, v); check("R2 level empty", v, 0);
        for (int i = 0; i < 16; i++) begin
            q[i] = int'($urandom % 256);
            wr(0, q[i]);
            if (i == 4) begin rd(5, v); check("R2 level five", v, 5); end
        end
        rd(5, v); check("R2 level full", v, 16);
        rd(3, v); check("R3 no overflow yet", v & 2, 0);
        wr(0, 8'hEE);
        rd(5, v); check("R3 level stays full", v, 16);
        rd(3, v); check("R3 overflow set", v & 2, 2);
        wr(1, 16'h0005);
        for (int i = 0; i < 16; i++) begin
            rx_frame(1'b1, 1'b0, 1'b0, bit_period(0), d, p, ok);
            check("R2 byte order", d, q[i]);
            check("R4 frame shape", ok, 1);
        end
        wait_idle();
        rd(3, v); check("R3 overflow sticky", v & 2, 2);
        wr(3, 2);
        rd(3, v); check("R3 overflow cleared", v & 2, 0);

        // R11 queue reset
        wr(1, 16'h0004);
        wr(0, 1); wr(0, 2); wr(0, 3);
        wr(4, 16'h000D);
        rd(4, v); check("R11 reset bits pending", v, 16'h000D);
        rd(5, v); check("R11 level before clear", v, 3);
        @(negedge clk);
        rd(4, v); check("R11 reset bits cleared", v, 16'h0001);
        rd(5, v); check("R11 level cleared", v, 0);

        // R10 disabled transmitter holds bytes
        wr(0, 8'h3C); wr(0, 8'hC3);
        cnt = 0;
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b1) cnt++;
        end
        check("R10 line quiet when disabled", cnt, 0);
        rd(5, v); check("R10 bytes kept", v, 2);
        wr(1, 16'h0005);
        rx_frame(1'b1, 1'b0, 1'b0, bit_period(0), d, p, ok);
        check("R10 first byte after enable", d, 8'h3C);
        rx_frame(1'b1, 1'b0, 1'b0, bit_period(0), d, p, ok);
        check("R10 second byte after enable", d, 8'hC3);
        wait_idle();

        // R9 break
        wr(1, 16'h0204);
        check("R9 break low", int'(txd), 0);
        repeat (20) @(negedge clk);
        check("R9 break held", int'(txd), 0);
        wr(1, 16'h0004);
        check("R9 release high", int'(txd), 1);

        // R8 divisor guard during a frame
        wr(0, 8'h81);
        wr(1, 16'h0005);
        while (txd !== 1'b0) @(negedge clk);
        rd(3, v); check("R8 busy during frame", (v >> 5) & 1, 1);
        wr(2, 16'h0003);
        rd(2, v); check("R8 divisor write ignored", v, 0);
        wait_idle();
        rd(3, v); check("R8 busy clear when idle", (v >> 5) & 1, 0);
        wr(2, 16'h0002);
        rd(2, v); check("R8 divisor write accepted", v, 2);

        // R4 R5 R6 random formats
        for (int r = 0; r < 10; r++) begin
            bit c8, pe, po, ts;
            int dv, n, per;
            c8 = 1'($urandom % 2);
            pe = (r < 2) ? 1'b1 : 1'($urandom % 2);
            po = (r == 0) ? 1'b0 : (r == 1) ? 1'b1 : 1'($urandom % 2);
            ts = (r == 2) ? 1'b1 : 1'($urandom % 2);
            dv = int'($urandom % 3);
            n  = 2 + int'($urandom % 4);
            per = bit_period(dv);
            wait_idle();
            wr(1, (int'(c8) << 2) | (int'(ts) << 3) | (int'(pe) << 4) | (int'(po) << 5));
            wr(2, dv);
            for (int i = 0; i < n; i++) begin
                q[i] = int'($urandom % 256);
                wr(0, q[i]);
            end
            wr(1, 1 | (int'(c8) << 2) | (int'(ts) << 3) | (int'(pe) << 4) | (int'(po) << 5));
            for (int i = 0; i < n; i++) begin
                rx_frame(c8, pe, ts, per, d, p, ok);
                check("R4 data bits", d, c8 ? q[i] : (q[i] & 8'h7F));
                if (pe) check("R5 parity bit", p, exp_parity(q[i], c8, po));
                check("R6 start and stop bits", ok, 1);
            end
        end
        wait_idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule